// File: doc/BRIEF.md
# Half-Period Duty Window Checker

This block watches a free-running square-wave input that has no timing relation to the local clock. It measures how many clock cycles the input spends high and how many it spends low. Each time a full period completes, it reports both half counts and their sum. The sum is the period length in the same units.

Each half is judged against an acceptance window. The window is given as a fraction of the measured period, so the check depends only on the ratio between the halves. Absolute timing does not matter, and the block needs no calibrated timebase.

A half that runs far too long stops counting at the largest count rather than wrapping. Such a half is always reported as a violation. The window limits are two numerators over a power-of-two denominator. The limits are applied with multiply-and-compare, and no divider is needed.

Top module: `duty_window_checker`

## Requirements
- R1: While `rst_n` is low and in the cycles after it is released, `high_cnt`, `low_cnt` and `period_cnt` are zero, and `result_valid`, `viol_high` and `viol_low` are low, until the first result is produced.
- R2: `sig_in` passes through a two-stage synchronizer. Edges are ignored while the synchronizer fills after reset. A half already under way when measurement starts is discarded. The first result needs a rising edge, a whole high half, then a whole low half ending at the next rising edge.
- R3: `high_cnt` equals the number of clock cycles the input stayed high. `low_cnt` equals the number of clock cycles it stayed low in the same period, with the high half coming first.
- R4: Whenever a result is reported, `period_cnt` equals `high_cnt + low_cnt`.
- R5: `result_valid` is a single-cycle pulse, issued exactly once for each complete high-then-low period.
- R6: `viol_high` is 1 when `high_cnt*2^FRAC_W < win_lo_num*period_cnt` or `high_cnt*2^FRAC_W > win_hi_num*period_cnt`. `viol_low` applies the same rule to `low_cnt`, independently of the high half.
- R7: Both window limits are inclusive. A half exactly equal to either limit is not a violation.
- R8: The half counters have `CNT_W = clog2(NOM_HALF+1)+1` bits, which gives at least one spare bit. They saturate at `2^CNT_W-1` and do not wrap. A saturated half always sets its violation flag, whatever the window.
- R9: All result outputs hold their values between `result_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| sig_in | input | 1 | Asynchronous periodic input being checked |
| win_lo_num | input | FRAC_W+1 | Lower window limit, numerator over 2^FRAC_W |
| win_hi_num | input | FRAC_W+1 | Upper window limit, numerator over 2^FRAC_W |
| high_cnt | output | CNT_W | Latched length of the last high half, in clock cycles |
| low_cnt | output | CNT_W | Latched length of the last low half, in clock cycles |
| period_cnt | output | CNT_W+1 | Sum of the two latched halves |
| result_valid | output | 1 | One-cycle strobe when a new period result is ready |
| viol_high | output | 1 | High half outside the window, or saturated |
| viol_low | output | 1 | Low half outside the window, or saturated |

## Verification
The in-line assertions check four things on every cycle. A strobe never lasts two cycles. The reported period is the sum of its halves. A saturated count never escapes its violation flag, and a saturated counter never wraps. The outputs stay frozen between strobes.

Other behaviour can only be shown by the directed scenarios, because it depends on the shape of the input waveform. This covers the exact cycle counts for given high and low lengths and the discarding of the partial half after reset. It also covers the number of strobes per run of periods and the inclusive window edges.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

  // Counter width: enough for the nominal half plus one headroom bit.
  function automatic int unsigned half_width(input int unsigned nominal);
    return $clog2(nominal + 1) + 1;
  endfunction

  // True when half/total lies outside [lo_num, hi_num] / 2^fw.
  // Cross-multiplied, so no division is required.
  function automatic logic outside_window(input logic [31:0] half,
                                          input logic [31:0] total,
                                          input logic [31:0] lo_num,
                                          input logic [31:0] hi_num,
                                          input int unsigned fw);
    logic [63:0] scaled;
    logic [63:0] lo_lim;
    logic [63:0] hi_lim;
    scaled = {32'd0, half} << fw;
    lo_lim = {32'd0, lo_num} * {32'd0, total};
    hi_lim = {32'd0, hi_num} * {32'd0, total};
    return (scaled < lo_lim) || (scaled > hi_lim);
  endfunction

endpackage

// File: rtl/dwc_edge_sync.sv
module dwc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_async,
  output logic rise_o,
  output logic fall_o
);
  logic       meta_q;
  logic       sync_q;
  logic       prev_q;
  logic [1:0] fill_q;
  logic       primed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
      fill_q <= 2'd0;
    end else begin
      meta_q <= sig_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
      if (fill_q != 2'd3) fill_q <= fill_q + 2'd1;
    end
  end

  // Edges are only trusted once every stage holds a real sample.
  assign primed = (fill_q == 2'd3);
  assign rise_o = primed &  sync_q & ~prev_q;
  assign fall_o = primed & ~sync_q &  prev_q;

  // R5: a level change needs two cycles to repeat in the same direction.
  a_r5_rise_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dwc_half_timer.sv
module dwc_half_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  output logic [CNT_W-1:0] held_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      held_o <= '0;
    end else if (stop_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      if (run_q) held_o <= cnt_q;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1};
    end else if (run_q && cnt_q != CNT_TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // A half only counts as finished if its start was seen.
  assign done_o = stop_i & run_q;

  // R8: once at the top the count stays there until the half ends.
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == CNT_TOP && !stop_i) |=> (cnt_q == CNT_TOP));
endmodule

// File: rtl/dwc_window_judge.sv
module dwc_window_judge
  import dwc_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 6
) (
  input  logic [CNT_W-1:0] half_i,
  input  logic [CNT_W:0]   total_i,
  input  logic [FRAC_W:0]  lo_num_i,
  input  logic [FRAC_W:0]  hi_num_i,
  output logic             viol_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic saturated;
  logic off_window;

  assign saturated  = (half_i == CNT_TOP);
  assign off_window = outside_window(32'(half_i), 32'(total_i),
                                     32'(lo_num_i), 32'(hi_num_i),
                                     FRAC_W);
  assign viol_o = saturated | off_window;
endmodule

// File: rtl/duty_window_checker.sv
module duty_window_checker
  import dwc_pkg::*;
#(
  parameter int NOM_HALF = 100,
  parameter int FRAC_W   = 6,
  parameter int CNT_W    = half_width(NOM_HALF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic [FRAC_W:0]  win_lo_num,
  input  logic [FRAC_W:0]  win_hi_num,
  output logic [CNT_W-1:0] high_cnt,
  output logic [CNT_W-1:0] low_cnt,
  output logic [CNT_W:0]   period_cnt,
  output logic             result_valid,
  output logic             viol_high,
  output logic             viol_low
);
  localparam int HI = 0;
  localparam int LO = 1;
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic             rise_ev;
  logic             fall_ev;
  logic [1:0]       half_start;
  logic [1:0]       half_stop;
  logic [1:0]       half_done;
  logic [CNT_W-1:0] half_held [2];
  logic [1:0]       half_viol;
  logic [CNT_W:0]   sum_now;
  logic             have_high_q;
  logic             publish_q;

  dwc_edge_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_async (sig_in),
    .rise_o    (rise_ev),
    .fall_o    (fall_ev)
  );

  // High half runs rise->fall, low half runs fall->rise.
  assign half_start = {fall_ev, rise_ev};
  assign half_stop  = {rise_ev, fall_ev};
  assign sum_now    = {1'b0, half_held[HI]} + {1'b0, half_held[LO]};

  for (genvar g = 0; g < 2; g++) begin : g_half
    dwc_half_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (half_start[g]),
      .stop_i  (half_stop[g]),
      .held_o  (half_held[g]),
      .done_o  (half_done[g])
    );
    dwc_window_judge #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_judge (
      .half_i   (half_held[g]),
      .total_i  (sum_now),
      .lo_num_i (win_lo_num),
      .hi_num_i (win_hi_num),
      .viol_o   (half_viol[g])
    );
  end

  // Pair a finished high half with the low half that follows it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_high_q <= 1'b0;
      publish_q   <= 1'b0;
    end else begin
      publish_q <= half_done[LO] & have_high_q;
      if (half_done[HI])      have_high_q <= 1'b1;
      else if (half_done[LO]) have_high_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      high_cnt     <= '0;
      low_cnt      <= '0;
      period_cnt   <= '0;
      result_valid <= 1'b0;
      viol_high    <= 1'b0;
      viol_low     <= 1'b0;
    end else begin
      result_valid <= publish_q;
      if (publish_q) begin
        high_cnt   <= half_held[HI];
        low_cnt    <= half_held[LO];
        period_cnt <= sum_now;
        viol_high  <= half_viol[HI];
        viol_low   <= half_viol[LO];
      end
    end
  end

  // R5: strobe lasts exactly one cycle.
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  // R4: published period is the sum of the published halves.
  a_r4_period_sum: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (period_cnt == {1'b0, high_cnt} + {1'b0, low_cnt}));
  // R8: a saturated half is never reported as passing.
  a_r8_sat_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && (high_cnt == CNT_TOP)) |-> viol_high);
  a_r8_sat_flagged_low: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && (low_cnt == CNT_TOP)) |-> viol_low);
  // R9: results are frozen between strobes.
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> ($stable(high_cnt) && $stable(viol_high) && $stable(viol_low)));
endmodule

// File: tb/duty_window_checker_tb.sv
module duty_window_checker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NOM_HALF   = 20;
  localparam int FRAC_W     = 6;
  localparam int CNT_W      = 6;   // clog2(21)+1
  localparam int CNT_TOP    = 63;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sig_in = 1'b0;
  logic [FRAC_W:0]  win_lo_num = 7'd24;
  logic [FRAC_W:0]  win_hi_num = 7'd40;
  logic [CNT_W-1:0] high_cnt;
  logic [CNT_W-1:0] low_cnt;
  logic [CNT_W:0]   period_cnt;
  logic             result_valid;
  logic             viol_high;
  logic             viol_low;

  int total = 0;
  int bad   = 0;
  int res_n = 0;
  int first_h = -1;
  int first_l = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  duty_window_checker #(.NOM_HALF(NOM_HALF), .FRAC_W(FRAC_W)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sig_in       (sig_in),
    .win_lo_num   (win_lo_num),
    .win_hi_num   (win_hi_num),
    .high_cnt     (high_cnt),
    .low_cnt      (low_cnt),
    .period_cnt   (period_cnt),
    .result_valid (result_valid),
    .viol_high    (viol_high),
    .viol_low     (viol_low)
  );

  // Observe strobes shortly after each rising edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && result_valid) begin
      res_n++;
      if (res_n == 1) begin
        first_h = int'(high_cnt);
        first_l = int'(low_cnt);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent restatement of the window rule (R6, R7, R8).
  function automatic int expect_viol(input int half, input int per,
                                     input int lo, input int hi);
    if (half == CNT_TOP) return 1;
    if (half * (1 << FRAC_W) < lo * per) return 1;
    if (half * (1 << FRAC_W) > hi * per) return 1;
    return 0;
  endfunction

  task automatic do_reset(input logic level);
    @(negedge clk);
    rst_n  = 1'b0;
    sig_in = level;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_periods(input int h, input int l, input int n);
    for (int i = 0; i < n; i++) begin
      sig_in = 1'b1;
      repeat (h) @(negedge clk);
      sig_in = 1'b0;
      repeat (l) @(negedge clk);
    end
    sig_in = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic check_result(input string tag, input int h, input int l,
                              input int lo, input int hi);
    int eh;
    int el;
    eh = (h > CNT_TOP) ? CNT_TOP : h;
    el = (l > CNT_TOP) ? CNT_TOP : l;
    chk({tag, " R3 high_cnt"}, int'(high_cnt), eh);
    chk({tag, " R3 low_cnt"}, int'(low_cnt), el);
    chk({tag, " R4 period_cnt"}, int'(period_cnt), eh + el);
    chk({tag, " R6 viol_high"}, int'(viol_high), expect_viol(eh, eh + el, lo, hi));
    chk({tag, " R6 viol_low"}, int'(viol_low), expect_viol(el, eh + el, lo, hi));
  endtask

  task automatic t_reset_state();
    do_reset(1'b0);
    repeat (3) @(negedge clk);
    chk("R1 high_cnt", int'(high_cnt), 0);
    chk("R1 period_cnt", int'(period_cnt), 0);
    chk("R1 result_valid", int'(result_valid), 0);
    chk("R1 viol", int'({viol_high, viol_low}), 0);
  endtask

  task automatic t_balanced();
    res_n = 0;
    win_lo_num = 7'd24;
    win_hi_num = 7'd40;
    run_periods(10, 10, 4);
    chk("R5 strobes per period", res_n, 4);
    check_result("balanced", 10, 10, 24, 40);
    repeat (6) @(negedge clk);
    chk("R9 hold high_cnt", int'(high_cnt), 10);
    chk("R9 hold period_cnt", int'(period_cnt), 20);
  endtask

  task automatic t_skewed();
    win_lo_num = 7'd16;
    win_hi_num = 7'd40;
    run_periods(13, 7, 3);
    check_result("skewed", 13, 7, 16, 40);
    chk("R6 high only flagged", int'({viol_high, viol_low}), 2);
  endtask

  task automatic t_boundary();
    win_lo_num = 7'd24;
    win_hi_num = 7'd40;
    run_periods(10, 6, 3);
    check_result("edge-in", 10, 6, 24, 40);
    chk("R7 exact limits pass", int'({viol_high, viol_low}), 0);
    win_hi_num = 7'd39;
    run_periods(10, 6, 3);
    chk("R7 just over upper", int'(viol_high), 1);
    chk("R7 lower still exact", int'(viol_low), 0);
  endtask

  task automatic t_saturate();
    win_lo_num = 7'd0;
    win_hi_num = 7'd64;
    run_periods(80, 20, 2);
    check_result("sat", 80, 20, 0, 64);
    chk("R8 saturated high", int'(high_cnt), CNT_TOP);
    chk("R8 saturated flagged", int'(viol_high), 1);
  endtask

  task automatic t_partial_start();
    win_lo_num = 7'd24;
    win_hi_num = 7'd40;
    do_reset(1'b1);
    res_n = 0;
    repeat (30) @(negedge clk);
    sig_in = 1'b0;
    repeat (5) @(negedge clk);
    sig_in = 1'b1;
    repeat (8) @(negedge clk);
    chk("R2 no result from partial half", res_n, 0);
    sig_in = 1'b0;
    repeat (5) @(negedge clk);
    sig_in = 1'b1;
    repeat (8) @(negedge clk);
    chk("R2 one result after full period", res_n, 1);
    chk("R2 first high", first_h, 8);
    chk("R2 first low", first_l, 5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_balanced();
    t_skewed();
    t_boundary();
    t_saturate();
    t_partial_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule